// File: doc/BRIEF.md
# Min-Sum Check Node Unit

This block is the check-side processing element of a scaled min-sum LDPC decoder built around a regular code in which every parity equation touches six bits. Each time it is given a set of six edge messages, it returns six new messages, one per edge. The magnitude of each returned message is the smallest magnitude found on the other five edges. Its sign is the product of the other five signs. Incoming messages are 5-bit two's complement values with two fractional bits. Outgoing messages use the same format, so the unit can sit between message memories with no extra conversion.

In the same pass the unit also takes the six hard-decision bits that the bit-side units produced in the previous iteration. It reports whether they satisfy this unit's parity equation, so the decoder can detect a valid codeword without a separate check phase. All results are registered and come out one cycle after the inputs are presented.

Top module: `minsum_check_node`

## Requirements
- R1: `out_valid` equals the value `in_valid` had at the previous rising clock edge. While reset is asserted, `out_valid`, `parity_ok` and every output lane are 0.
- R2: The magnitude of output lane i equals the minimum, over all lanes j other than i, of |in_j|. Lane k occupies bits [5k+4:5k] of the flat message vectors.
- R3: An input of -16 (5'b10000) is treated as magnitude 15, so no output magnitude ever exceeds 15.
- R4: The sign of output lane i is the XOR of the sign bits (bit 4 of each lane) of the five other input lanes. A sign of 1 gives a negative output.
- R5: When the selected magnitude of a lane is 0, that lane outputs 0, whatever its computed sign. No output lane ever carries 5'b10000.
- R6: Output lanes are two's complement. A negative result of magnitude m is encoded as 32-m in 5 bits.
- R7: `parity_ok` is 1 when the XOR of the six `code_bits` sampled with `in_valid` is 0, and 0 otherwise.
- R8: In a cycle where `in_valid` is 0, the output lanes and `parity_ok` keep their previous values, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A message set and code bits are presented this cycle |
| in_msg | input | 30 | Six 5-bit two's complement incoming messages, lane k at [5k+4:5k] |
| code_bits | input | 6 | Hard decisions of the previous iteration, one per edge |
| out_valid | output | 1 | Registered results are fresh |
| out_msg | output | 30 | Six 5-bit two's complement outgoing messages, same lane layout |
| parity_ok | output | 1 | 1 when the previous hard decisions satisfy this parity equation |

## Verification
The first stimulus uses only positive inputs with distinct magnitudes. This isolates the excluded-minimum selection from sign handling, and a duplicated minimum shows that excluding one lane still leaves its twin. Mixed-sign random sets then test the XOR-of-others sign rule. Sets containing -16 separate a saturating magnitude from a wrapped one. Zeros placed next to negative inputs expose any negative-zero encoding. All 64 code-bit patterns are swept for the parity flag, and bursts with `in_valid` low and changing inputs show whether the registers truly hold.

// File: rtl/cnu_pkg.sv
package cnu_pkg;
  localparam int unsigned CNU_DEG_DEF   = 6;
  localparam int unsigned CNU_MSG_W_DEF = 5;

  // Largest magnitude representable in a message of the given width
  function automatic int unsigned cnu_mag_max(input int unsigned msg_w);
    return (1 << (msg_w - 1)) - 1;
  endfunction
endpackage

// File: rtl/cnu_abs_sat.sv
module cnu_abs_sat #(
  parameter int unsigned MSG_W = 5,
  localparam int unsigned MAG_W = MSG_W - 1
) (
  input  logic [MSG_W-1:0] msg_i,
  output logic             sign_o,
  output logic [MAG_W-1:0] mag_o
);
  logic [MSG_W-1:0] negated;

  always_comb begin
    sign_o  = msg_i[MSG_W-1];
    negated = ~msg_i + 1'b1;
    if (!msg_i[MSG_W-1]) begin
      mag_o = msg_i[MAG_W-1:0];
    end else if (negated[MSG_W-1]) begin
      // most negative code: clamp to largest magnitude
      mag_o = {MAG_W{1'b1}};
    end else begin
      mag_o = negated[MAG_W-1:0];
    end
  end

  always_comb begin
    // R3: magnitude never wraps to zero for a negative input
    a_r3_neg_nonzero: assert (!(msg_i[MSG_W-1] && mag_o == '0));
  end
endmodule

// File: rtl/cnu_excl_min.sv
module cnu_excl_min #(
  parameter int unsigned DEG   = 6,
  parameter int unsigned MAG_W = 4
) (
  input  logic [DEG*MAG_W-1:0] mag_i,
  output logic [DEG*MAG_W-1:0] min_o
);
  logic [MAG_W-1:0] lane [DEG];
  logic [MAG_W-1:0] pre  [DEG+1];
  logic [MAG_W-1:0] suf  [DEG+1];

  assign pre[0]   = {MAG_W{1'b1}};
  assign suf[DEG] = {MAG_W{1'b1}};

  for (genvar k = 0; k < DEG; k++) begin : g_lane
    assign lane[k] = mag_i[k*MAG_W +: MAG_W];
    // running minimum from the low end and from the high end
    assign pre[k+1] = (lane[k] < pre[k]) ? lane[k] : pre[k];
    assign suf[k]   = (lane[k] < suf[k+1]) ? lane[k] : suf[k+1];
    // excluded minimum joins the two partial results around lane k
    assign min_o[k*MAG_W +: MAG_W] = (pre[k] < suf[k+1]) ? pre[k] : suf[k+1];
  end

  always_comb begin
    for (int i = 0; i < DEG; i++) begin
      for (int j = 0; j < DEG; j++) begin
        if (i != j) begin
          // R2: selected value never exceeds any other lane
          a_r2_min_bound: assert (min_o[i*MAG_W +: MAG_W] <= lane[j]);
        end
      end
    end
  end
endmodule

// File: rtl/cnu_sm_to_tc.sv
module cnu_sm_to_tc #(
  parameter int unsigned MSG_W = 5,
  localparam int unsigned MAG_W = MSG_W - 1
) (
  input  logic             sign_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic [MSG_W-1:0] tc_o
);
  logic [MSG_W-1:0] pos;

  always_comb begin
    pos = {1'b0, mag_i};
    if (sign_i && (mag_i != '0)) begin
      tc_o = ~pos + 1'b1;
    end else begin
      tc_o = pos;
    end
  end

  always_comb begin
    // R6: the encoded sign bit is set only for a nonzero negative result
    a_r6_sign_bit: assert (tc_o[MSG_W-1] == (sign_i && (mag_i != '0)));
  end
endmodule

// File: rtl/minsum_check_node.sv
module minsum_check_node
  import cnu_pkg::*;
#(
  parameter int unsigned DEG   = CNU_DEG_DEF,
  parameter int unsigned MSG_W = CNU_MSG_W_DEF,
  localparam int unsigned MAG_W = MSG_W - 1,
  localparam int unsigned VEC_W = DEG * MSG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] in_msg,
  input  logic [DEG-1:0]   code_bits,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_msg,
  output logic             parity_ok
);
  logic [DEG-1:0]       sign_in;
  logic [DEG*MAG_W-1:0] mag_in;
  logic [DEG*MAG_W-1:0] mag_sel;
  logic [DEG-1:0]       sign_out;
  logic                 sign_all;
  logic [VEC_W-1:0]     msg_d, msg_q;
  logic                 par_d, par_q;
  logic                 vld_d, vld_q;

  for (genvar k = 0; k < DEG; k++) begin : g_in
    cnu_abs_sat #(.MSG_W(MSG_W)) u_abs (
      .msg_i  (in_msg[k*MSG_W +: MSG_W]),
      .sign_o (sign_in[k]),
      .mag_o  (mag_in[k*MAG_W +: MAG_W])
    );
  end

  cnu_excl_min #(.DEG(DEG), .MAG_W(MAG_W)) u_min (
    .mag_i (mag_in),
    .min_o (mag_sel)
  );

  assign sign_all = ^sign_in;

  for (genvar k = 0; k < DEG; k++) begin : g_out
    // removing lane k's own sign from the total leaves the others' product
    assign sign_out[k] = sign_all ^ sign_in[k];
    cnu_sm_to_tc #(.MSG_W(MSG_W)) u_tc (
      .sign_i (sign_out[k]),
      .mag_i  (mag_sel[k*MAG_W +: MAG_W]),
      .tc_o   (msg_d[k*MSG_W +: MSG_W])
    );
  end

  // next-state
  always_comb begin
    vld_d = in_valid;
    par_d = ~(^code_bits);
  end

  // registers; data captured only on valid
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      msg_q <= '0;
      par_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (in_valid) begin
        msg_q <= msg_d;
        par_q <= par_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_msg   = msg_q;
  assign parity_ok = par_q;

  a_r1_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_msg) && $stable(parity_ok)));
  a_r7_parity: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (parity_ok == $past(($countones(code_bits) % 2) == 0)));

  for (genvar k = 0; k < DEG; k++) begin : g_chk
    a_r5_no_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_msg[k*MSG_W +: MSG_W] != {1'b1, {MAG_W{1'b0}}});
  end
endmodule

// File: tb/tb_minsum_check_node.sv
module tb_minsum_check_node;
  localparam int DEG = 6;
  localparam int W   = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic [DEG*W-1:0] in_msg;
  logic [DEG-1:0]   code_bits;
  logic             out_valid;
  logic [DEG*W-1:0] out_msg;
  logic             parity_ok;

  int    checks = 0;
  int    bad    = 0;
  bit    done   = 0;
  string cur_tag = "R1";

  // reference state
  int exp_msg [DEG];
  bit exp_vld;
  bit exp_par;

  always #10 clk = ~clk;

  minsum_check_node dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_msg(in_msg),
    .code_bits(code_bits), .out_valid(out_valid), .out_msg(out_msg),
    .parity_ok(parity_ok)
  );

  function automatic int lane_in(int k);
    int v;
    v = int'(in_msg[k*W +: W]);
    if (v >= 16) v -= 32;
    return v;
  endfunction

  function automatic int mag_of(int v);
    int m;
    m = (v < 0) ? -v : v;
    return (m > 15) ? 15 : m;
  endfunction

  // behavioural model: updated on each clock edge from the sampled inputs
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_vld = 0;
      exp_par = 0;
      for (int k = 0; k < DEG; k++) exp_msg[k] = 0;
    end else begin
      exp_vld = in_valid;
      if (in_valid) begin
        int ones;
        ones = 0;
        for (int k = 0; k < DEG; k++) ones += code_bits[k];
        exp_par = (ones % 2) == 0;
        for (int i = 0; i < DEG; i++) begin
          int m;
          bit s;
          m = 15;
          s = 0;
          for (int j = 0; j < DEG; j++) begin
            if (j != i) begin
              if (mag_of(lane_in(j)) < m) m = mag_of(lane_in(j));
              if (lane_in(j) < 0) s = ~s;
            end
          end
          exp_msg[i] = (m == 0) ? 0 : (s ? -m : m);
        end
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (out_valid !== exp_vld) begin
        bad++;
        $display("FAIL R1 out_valid got %0d exp %0d", out_valid, exp_vld);
      end
      checks++;
      if (parity_ok !== exp_par) begin
        bad++;
        $display("FAIL %s parity_ok got %0d exp %0d", cur_tag, parity_ok, exp_par);
      end
      for (int k = 0; k < DEG; k++) begin
        logic [W-1:0] e;
        e = W'(exp_msg[k]);
        checks++;
        if (out_msg[k*W +: W] !== e) begin
          bad++;
          $display("FAIL %s lane %0d got %0d exp %0d", cur_tag, k,
                   out_msg[k*W +: W], e);
        end
      end
    end
  end

  task automatic drive(input bit v, input int a0, input int a1, input int a2,
                       input int a3, input int a4, input int a5, input logic [5:0] cb);
    @(negedge clk);
    in_valid  = v;
    in_msg    = {W'(a5), W'(a4), W'(a3), W'(a2), W'(a1), W'(a0)};
    code_bits = cb;
  endtask

  task automatic drive_rand(input bit v, input int lo, input int hi);
    int span;
    span = hi - lo + 1;
    @(negedge clk);
    in_valid = v;
    for (int k = 0; k < DEG; k++)
      in_msg[k*W +: W] = W'(lo + int'($urandom % span));
    code_bits = 6'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL R1 watchdog expired got hung exp finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_msg = '0; code_bits = '0;
    cur_tag = "R1";
    repeat (3) @(negedge clk);     // reset state compared each negedge
    rst_n = 1;

    // R2: positive, distinct magnitudes, then duplicated minimum
    cur_tag = "R2";
    drive(1, 3, 7, 1, 9, 5, 12, 6'b000000);
    drive(1, 4, 2, 8, 2, 11, 6, 6'b000011);
    drive(1, 15, 15, 15, 15, 15, 15, 6'b111111);
    for (int n = 0; n < 200; n++) drive_rand(1, 0, 15);

    // R4 and R6: mixed signs
    cur_tag = "R4";
    drive(1, -3, 7, -1, 9, 5, -12, 6'b101010);
    drive(1, -2, -2, -2, -2, -2, -2, 6'b000001);
    cur_tag = "R6";
    for (int n = 0; n < 300; n++) drive_rand(1, -15, 15);

    // R3: most negative code
    cur_tag = "R3";
    drive(1, -16, -16, -16, -16, -16, -16, 6'b0);
    drive(1, -16, 15, -16, 15, -16, 15, 6'b0);
    for (int n = 0; n < 200; n++) drive_rand(1, -16, 15);

    // R5: zeros beside negatives
    cur_tag = "R5";
    drive(1, 0, -3, 4, 5, 6, 7, 6'b0);
    drive(1, 0, 0, -5, -6, -7, -1, 6'b0);
    for (int n = 0; n < 200; n++) drive_rand(1, -2, 1);

    // R7: every code-bit pattern
    cur_tag = "R7";
    for (int c = 0; c < 64; c++) drive(1, 1, 2, 3, 4, 5, 6, 6'(c));

    // R8: hold while invalid, with valid toggling
    cur_tag = "R8";
    drive(1, 5, -6, 7, -8, 9, -10, 6'b000111);
    for (int n = 0; n < 40; n++) drive_rand(0, -16, 15);
    for (int n = 0; n < 300; n++) drive_rand(n % 3 == 0, -16, 15);

    // R1: valid drop and rise
    cur_tag = "R1";
    drive(0, 0, 0, 0, 0, 0, 0, 6'b0);
    drive(1, 1, 1, 1, 1, 1, 1, 6'b0);
    drive(0, 2, 2, 2, 2, 2, 2, 6'b0);
    repeat (3) @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule